// File: doc/BRIEF.md
# Link Rate and Lane Fallback Controller

This block runs the outer retry loop of a serial display link bring-up. A `power_on` pulse loads a starting bandwidth code and lane count. Each attempt then follows the same order: the link clock is enabled, the main link is enabled, and a one-cycle start pulse goes to an external training sequencer. The controller then waits for that sequencer's done strobe and result code. The training phases themselves live outside this block.

When an attempt fails, the controller may take one of two actions: it may accept a lane reduction, or it may step the bandwidth code down one rung. It then turns off the main link, stops the link clock and waits a settle delay before the next attempt. There is a bounded retry budget and a sticky abort. In shallow mode any failed attempt ends the run as a success, with the link left up. All pins are plain control and status; there is no streaming data path, so no valid/ready handshake applies.

Top module: `link_fallback_ctrl`

## Requirements
- R1: After reset the block is idle with `link_clk_en`, `mainlink_en`, `busy` and `setup_done` low, `bw_code` = 0x06 and `lane_count` = 1.
- R2: A `power_on` pulse loads `init_bw` and `init_lanes` and starts an attempt. `link_clk_en` rises first, then `mainlink_en`, then `train_start` pulses for one cycle with both enables high.
- R3: Result 0 (pass) ends the run. `setup_done` pulses for one cycle with `setup_ok`=1 and `setup_err`=0, and the link clock and main link stay enabled.
- R4: Result 1 (hard failure) lowers the bandwidth code for the next attempt. The steps are 0x1E to 0x14, 0x14 to 0x0A, 0x0A to 0x06, and 0x06 stays at 0x06. The lane count does not change.
- R5: Result 2 (lane request) with `sink_rev` = 0x14 reduces 4 lanes to 2 and 2 lanes to 1. The rate is kept, because the outcome counts as "retry again".
- R6: Result 2 with any other `sink_rev` is rejected. The lanes are kept, and the failure counts as hard, so the rate steps down.
- R7: Result 2 at 1 lane is accepted (rate kept) only if the run started with 1 lane. Otherwise it is a hard failure and the rate steps down.
- R8: Result 3 (retry same) changes neither the rate nor the lane count. A single failed attempt never changes both.
- R9: Between attempts `mainlink_en` drops before `link_clk_en`. The clock then stays off for at least the settle delay, which is SETTLE_MS milliseconds of REF_HZ cycles.
- R10: With no pass and no abort, the run ends after MAX_RETRY+1 attempts with `setup_ok`=0.
- R11: An `abort_req` pulse seen during a run makes the next failed attempt final. `setup_ok` is 0.
- R12: With `shallow`=1, a failed attempt ends the run with `setup_ok`=1 and `setup_err`=0, and both enables stay high.
- R13: On a final failure, `setup_err` is 1 when the last outcome was hard and 2 when it was "retry again" (result 3, or an accepted lane request).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_on | input | 1 | Start pulse, taken only while idle |
| init_bw | input | 8 | Starting bandwidth code |
| init_lanes | input | LANE_W | Starting lane count (1, 2 or 4) |
| sink_rev | input | REV_W | Sink protocol revision |
| shallow | input | 1 | Treat failed attempts as success |
| abort_req | input | 1 | Abort request pulse |
| link_clk_en | output | 1 | Link clock enable |
| mainlink_en | output | 1 | Main link enable |
| train_start | output | 1 | One-cycle start to the training sequencer |
| train_done | input | 1 | Training finished strobe |
| train_result | input | 2 | 0 pass, 1 hard fail, 2 lane request, 3 retry same |
| bw_code | output | 8 | Current bandwidth code |
| lane_count | output | LANE_W | Current lane count |
| busy | output | 1 | Run in progress |
| setup_done | output | 1 | One-cycle end-of-run pulse |
| setup_ok | output | 1 | Run outcome, valid with `setup_done` |
| setup_err | output | 2 | 0 none, 1 hard, 2 retry again |

## Verification
The hardest state to reach is the end of the retry budget, because it needs MAX_RETRY+1 consecutive failed attempts, each with a full teardown and settle wait. The bench builds with a small reference frequency so that each settle wait is a few dozen cycles. It then answers every training request with a failure code until the budget runs out. A second hard case is a lane request at one lane. The bench reaches it by starting at four lanes with revision 0x14 and issuing lane requests until the count bottoms out, and it repeats the case with a one-lane start to cover both outcomes.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int BW_W = 8;

  localparam logic [BW_W-1:0] BW_RATE_LO  = 8'h06;
  localparam logic [BW_W-1:0] BW_RATE_MID = 8'h0A;
  localparam logic [BW_W-1:0] BW_RATE_HI  = 8'h14;
  localparam logic [BW_W-1:0] BW_RATE_TOP = 8'h1E;

  typedef enum logic [1:0] {
    TR_PASS  = 2'd0,
    TR_HARD  = 2'd1,
    TR_LANES = 2'd2,
    TR_AGAIN = 2'd3
  } train_res_e;

  typedef enum logic [1:0] {
    RC_NONE  = 2'd0,
    RC_HARD  = 2'd1,
    RC_AGAIN = 2'd2
  } fail_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLK_ON,
    ST_LINK_CFG,
    ST_TRAIN_GO,
    ST_TRAIN_WAIT,
    ST_TEARDOWN,
    ST_CLK_OFF,
    ST_SETTLE
  } fsm_e;
endpackage

// File: rtl/lfc_rate_ladder.sv
module lfc_rate_ladder
  import lfc_pkg::*;
(
  input  logic [BW_W-1:0] cur_bw,
  output logic [BW_W-1:0] lower_bw
);
  always_comb begin
    unique case (cur_bw)
      BW_RATE_TOP: lower_bw = BW_RATE_HI;
      BW_RATE_HI:  lower_bw = BW_RATE_MID;
      default:     lower_bw = BW_RATE_LO;
    endcase
  end
endmodule

// File: rtl/lfc_lane_shift.sv
module lfc_lane_shift #(
  parameter int                LANE_W   = 3,
  parameter int                REV_W    = 8,
  parameter logic [REV_W-1:0]  LANE_REV = 8'h14
) (
  input  logic [LANE_W-1:0] cur_lanes,
  input  logic [LANE_W-1:0] start_lanes,
  input  logic [REV_W-1:0]  sink_rev,
  output logic              accept,
  output logic [LANE_W-1:0] new_lanes
);
  localparam logic [LANE_W-1:0] L1 = LANE_W'(1);
  localparam logic [LANE_W-1:0] L2 = LANE_W'(2);
  localparam logic [LANE_W-1:0] L4 = LANE_W'(4);

  always_comb begin
    accept    = 1'b0;
    new_lanes = cur_lanes;
    if (sink_rev == LANE_REV) begin
      if (cur_lanes == L4) begin
        accept    = 1'b1;
        new_lanes = L2;
      end else if (cur_lanes == L2) begin
        accept    = 1'b1;
        new_lanes = L1;
      end else begin
        accept    = (cur_lanes == start_lanes);
      end
    end
  end
endmodule

// File: rtl/lfc_settle_timer.sv
module lfc_settle_timer #(
  parameter int unsigned CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= CW'(CYCLES - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);
endmodule

// File: rtl/lfc_retry_budget.sv
module lfc_retry_budget #(
  parameter int unsigned MAX_RETRY = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic consume,
  output logic empty
);
  localparam int unsigned CW = $clog2(MAX_RETRY + 2);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      left <= '0;
    else if (load)                   left <= CW'(MAX_RETRY);
    else if (consume && left != '0)  left <= left - 1'b1;
  end

  assign empty = (left == '0);
endmodule

// File: rtl/link_fallback_ctrl.sv
module link_fallback_ctrl
  import lfc_pkg::*;
#(
  parameter int               LANE_W    = 3,
  parameter int               REV_W     = 8,
  parameter logic [REV_W-1:0] LANE_REV  = 8'h14,
  parameter int unsigned      MAX_RETRY = 100,
  parameter int unsigned      REF_HZ    = 19_200_000,
  parameter int unsigned      SETTLE_MS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_on,
  input  logic [BW_W-1:0]   init_bw,
  input  logic [LANE_W-1:0] init_lanes,
  input  logic [REV_W-1:0]  sink_rev,
  input  logic              shallow,
  input  logic              abort_req,
  output logic              link_clk_en,
  output logic              mainlink_en,
  output logic              train_start,
  input  logic              train_done,
  input  logic [1:0]        train_result,
  output logic [BW_W-1:0]   bw_code,
  output logic [LANE_W-1:0] lane_count,
  output logic              busy,
  output logic              setup_done,
  output logic              setup_ok,
  output logic [1:0]        setup_err
);
  localparam int unsigned SETTLE_CYCLES_RAW = (REF_HZ / 1000) * SETTLE_MS;
  localparam int unsigned SETTLE_CYCLES = (SETTLE_CYCLES_RAW < 1) ? 1 : SETTLE_CYCLES_RAW;

  fsm_e              state;
  logic [BW_W-1:0]   bw_q;
  logic [LANE_W-1:0] lanes_q;
  logic [LANE_W-1:0] start_lanes_q;
  logic              abort_seen;
  logic              clk_en_q;
  logic              ml_en_q;
  logic              done_q;
  logic              ok_q;
  fail_kind_e        err_q;

  logic [BW_W-1:0]   lower_bw;
  logic              lane_accept;
  logic [LANE_W-1:0] lane_next;
  logic              timer_start;
  logic              timer_expired;
  logic              budget_load;
  logic              budget_use;
  logic              budget_empty;

  train_res_e        res;
  fail_kind_e        kind;
  logic              decide;
  logic              finish_ok;
  logic              finish_fail;
  logic              abort_now;

  lfc_rate_ladder u_ladder (
    .cur_bw   (bw_q),
    .lower_bw (lower_bw)
  );

  lfc_lane_shift #(
    .LANE_W   (LANE_W),
    .REV_W    (REV_W),
    .LANE_REV (LANE_REV)
  ) u_lanes (
    .cur_lanes   (lanes_q),
    .start_lanes (start_lanes_q),
    .sink_rev    (sink_rev),
    .accept      (lane_accept),
    .new_lanes   (lane_next)
  );

  lfc_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (timer_start),
    .expired (timer_expired)
  );

  lfc_retry_budget #(.MAX_RETRY(MAX_RETRY)) u_budget (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (budget_load),
    .consume (budget_use),
    .empty   (budget_empty)
  );

  // classify the finished attempt
  always_comb begin
    res       = train_res_e'(train_result);
    decide    = (state == ST_TRAIN_WAIT) && train_done;
    abort_now = abort_seen || abort_req;
    unique case (res)
      TR_PASS:  kind = RC_NONE;
      TR_HARD:  kind = RC_HARD;
      TR_LANES: kind = lane_accept ? RC_AGAIN : RC_HARD;
      default:  kind = RC_AGAIN;
    endcase
    finish_ok   = decide && ((res == TR_PASS) || shallow);
    finish_fail = decide && !finish_ok && (budget_empty || abort_now);
  end

  assign budget_load = (state == ST_IDLE) && power_on;
  assign budget_use  = decide && !finish_ok && !finish_fail;
  assign timer_start = (state == ST_CLK_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      bw_q          <= BW_RATE_LO;
      lanes_q       <= LANE_W'(1);
      start_lanes_q <= LANE_W'(1);
      abort_seen    <= 1'b0;
      clk_en_q      <= 1'b0;
      ml_en_q       <= 1'b0;
      done_q        <= 1'b0;
      ok_q          <= 1'b0;
      err_q         <= RC_NONE;
    end else begin
      done_q <= 1'b0;
      if (state != ST_IDLE && abort_req) abort_seen <= 1'b1;

      unique case (state)
        ST_IDLE: begin
          if (power_on) begin
            bw_q          <= init_bw;
            lanes_q       <= init_lanes;
            start_lanes_q <= init_lanes;
            abort_seen    <= 1'b0;
            state         <= ST_CLK_ON;
          end
        end
        ST_CLK_ON: begin
          clk_en_q <= 1'b1;
          state    <= ST_LINK_CFG;
        end
        ST_LINK_CFG: begin
          ml_en_q <= 1'b1;
          state   <= ST_TRAIN_GO;
        end
        ST_TRAIN_GO: begin
          state <= ST_TRAIN_WAIT;
        end
        ST_TRAIN_WAIT: begin
          if (decide) begin
            if (res == TR_LANES && lane_accept) lanes_q <= lane_next;
            if (finish_ok) begin
              done_q <= 1'b1;
              ok_q   <= 1'b1;
              err_q  <= RC_NONE;
              state  <= ST_IDLE;
            end else if (finish_fail) begin
              done_q <= 1'b1;
              ok_q   <= 1'b0;
              err_q  <= kind;
              state  <= ST_IDLE;
            end else begin
              if (kind == RC_HARD) bw_q <= lower_bw;
              state <= ST_TEARDOWN;
            end
          end
        end
        ST_TEARDOWN: begin
          ml_en_q <= 1'b0;
          state   <= ST_CLK_OFF;
        end
        ST_CLK_OFF: begin
          clk_en_q <= 1'b0;
          state    <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (timer_expired) state <= ST_CLK_ON;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign link_clk_en = clk_en_q;
  assign mainlink_en = ml_en_q;
  assign train_start = (state == ST_TRAIN_GO);
  assign bw_code     = bw_q;
  assign lane_count  = lanes_q;
  assign busy        = (state != ST_IDLE);
  assign setup_done  = done_q;
  assign setup_ok    = ok_q;
  assign setup_err   = err_q;
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker
  import lfc_pkg::*;
#(
  parameter int               LANE_W   = 3,
  parameter int               REV_W    = 8,
  parameter logic [REV_W-1:0] LANE_REV = 8'h14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REV_W-1:0]  sink_rev,
  input logic              link_clk_en,
  input logic              mainlink_en,
  input logic              train_start,
  input logic [BW_W-1:0]   bw_code,
  input logic [LANE_W-1:0] lane_count,
  input logic              busy,
  input logic              setup_done,
  input logic              setup_ok,
  input logic [1:0]        setup_err
);
  p_start_needs_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
    train_start |-> (link_clk_en && mainlink_en));

  p_link_needs_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mainlink_en |-> link_clk_en);

  p_rate_never_rises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (bw_code <= $past(bw_code)));

  p_rate_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_code == BW_RATE_LO) || (bw_code == BW_RATE_MID) ||
    (bw_code == BW_RATE_HI) || (bw_code == BW_RATE_TOP));

  p_lanes_never_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (lane_count <= $past(lane_count)));

  p_lanes_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_count) == 1);

  p_no_lane_cut_other_rev_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sink_rev != LANE_REV) |-> $stable(lane_count));

  p_single_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !(!$stable(bw_code) && !$stable(lane_count)));

  p_done_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |=> !setup_done);

  p_ok_no_error_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_done && setup_ok) |-> (setup_err == 2'd0));

  p_fail_has_error_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_done && !setup_ok) |-> (setup_err == 2'd1 || setup_err == 2'd2));
endmodule

bind link_fallback_ctrl lfc_checker #(
  .LANE_W   (LANE_W),
  .REV_W    (REV_W),
  .LANE_REV (LANE_REV)
) u_lfc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .sink_rev    (sink_rev),
  .link_clk_en (link_clk_en),
  .mainlink_en (mainlink_en),
  .train_start (train_start),
  .bw_code     (bw_code),
  .lane_count  (lane_count),
  .busy        (busy),
  .setup_done  (setup_done),
  .setup_ok    (setup_ok),
  .setup_err   (setup_err)
);

// File: tb/tb_link_fallback_ctrl.sv
`timescale 1ns/1ps
module tb_link_fallback_ctrl;
  localparam int LANE_W    = 3;
  localparam int REV_W     = 8;
  localparam int MAX_RETRY = 100;
  localparam int SETTLE    = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              power_on = 1'b0;
  logic [7:0]        init_bw = 8'h06;
  logic [LANE_W-1:0] init_lanes = 3'd1;
  logic [REV_W-1:0]  sink_rev = 8'h14;
  logic              shallow = 1'b0;
  logic              abort_req = 1'b0;
  logic              link_clk_en, mainlink_en, train_start;
  logic              train_done = 1'b0;
  logic [1:0]        train_result = 2'd0;
  logic [7:0]        bw_code;
  logic [LANE_W-1:0] lane_count;
  logic              busy, setup_done, setup_ok;
  logic [1:0]        setup_err;

  int errors = 0;
  int checks = 0;
  int last_attempts = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  link_fallback_ctrl #(
    .LANE_W(LANE_W), .REV_W(REV_W), .LANE_REV(8'h14),
    .MAX_RETRY(MAX_RETRY), .REF_HZ(1000), .SETTLE_MS(SETTLE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .power_on(power_on), .init_bw(init_bw),
    .init_lanes(init_lanes), .sink_rev(sink_rev), .shallow(shallow),
    .abort_req(abort_req), .link_clk_en(link_clk_en), .mainlink_en(mainlink_en),
    .train_start(train_start), .train_done(train_done), .train_result(train_result),
    .bw_code(bw_code), .lane_count(lane_count), .busy(busy),
    .setup_done(setup_done), .setup_ok(setup_ok), .setup_err(setup_err)
  );

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_lower(input logic [7:0] b);
    case (b)
      8'h1E:   return 8'h14;
      8'h14:   return 8'h0A;
      default: return 8'h06;
    endcase
  endfunction

  function automatic bit m_lane_ok(input int cur, input int init, input int rev);
    if (rev != 8'h14) return 0;
    if (cur == 4 || cur == 2) return 1;
    return cur == init;
  endfunction

  function automatic int m_lane_next(input int cur);
    if (cur == 4) return 2;
    if (cur == 2) return 1;
    return cur;
  endfunction

  task automatic wait_start(output int low_cycles, output int ml_bad);
    low_cycles = 0;
    ml_bad = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (train_start) return;
      if (!link_clk_en) begin
        low_cycles++;
        if (mainlink_en) ml_bad++;
      end
    end
    chk(0, "R2", "train_start never seen", 0, 1);
  endtask

  // result code per attempt: pass at pass_at, else mode (0 = random 1..3)
  task automatic run_case(input logic [7:0] bw0, input int ln0, input int rev,
                          input bit shl, input int mode, input int pass_at,
                          input int abort_at, input string tag);
    logic [7:0] exp_bw;
    int exp_ln, budget, k, low, mlb, res, rc;
    bit aborted, term, exp_ok;
    @(negedge clk);
    init_bw = bw0; init_lanes = LANE_W'(ln0); sink_rev = REV_W'(rev); shallow = shl;
    power_on = 1'b1;
    @(negedge clk);
    power_on = 1'b0;
    exp_bw = bw0; exp_ln = ln0; budget = MAX_RETRY; aborted = 0; term = 0;
    exp_ok = 0; rc = 0; k = 0;
    while (!term) begin
      wait_start(low, mlb);
      if (k == 0) begin
        chk(link_clk_en && mainlink_en, "R2", {tag, " enables at first start"},
            {link_clk_en, mainlink_en}, 3);
      end else begin
        chk(low >= SETTLE && low <= SETTLE + 2, "R9", {tag, " clock-off cycles"}, low, SETTLE + 1);
        chk(mlb == 0, "R9", {tag, " main link on while clock off"}, mlb, 0);
      end
      chk(bw_code == exp_bw, "R4", {tag, " bw at attempt"}, bw_code, exp_bw);
      chk(lane_count == LANE_W'(exp_ln), "R5", {tag, " lanes at attempt"}, lane_count, exp_ln);
      res = (k == pass_at) ? 0 : ((mode == 0) ? $urandom_range(1, 3) : mode);
      @(negedge clk);
      if (k == abort_at) begin
        abort_req = 1'b1; aborted = 1;
      end
      @(negedge clk);
      abort_req = 1'b0;
      train_done = 1'b1; train_result = 2'(res);
      @(negedge clk);
      train_done = 1'b0;
      // bench model of the decision
      if (res == 0) begin
        term = 1; exp_ok = 1;
      end else begin
        if (res == 1) rc = 1;
        else if (res == 3) rc = 2;
        else if (m_lane_ok(exp_ln, ln0, rev)) begin
          exp_ln = m_lane_next(exp_ln); rc = 2;
        end else rc = 1;
        if (shl) begin
          term = 1; exp_ok = 1;
        end else if (budget == 0 || aborted) begin
          term = 1; exp_ok = 0;
        end else begin
          budget--;
          if (rc == 1) exp_bw = m_lower(exp_bw);
        end
      end
      k++;
    end
    last_attempts = k;
    chk(setup_done == 1'b1, "R3", {tag, " done pulse"}, setup_done, 1);
    chk(setup_ok == exp_ok, exp_ok ? "R12" : "R10", {tag, " outcome"}, setup_ok, exp_ok);
    chk(setup_err == (exp_ok ? 2'd0 : 2'(rc)), "R13", {tag, " error kind"}, setup_err,
        exp_ok ? 0 : rc);
    chk(lane_count == LANE_W'(exp_ln), "R7", {tag, " final lanes"}, lane_count, exp_ln);
    chk(bw_code == exp_bw, "R4", {tag, " final bw"}, bw_code, exp_bw);
    if (exp_ok)
      chk(link_clk_en && mainlink_en, "R12", {tag, " link left up"},
          {link_clk_en, mainlink_en}, 3);
    @(negedge clk);
    chk(!setup_done && !busy, "R3", {tag, " pulse ends, idle"}, {setup_done, busy}, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] bws [4];
    int lns [3];
    bws[0] = 8'h06; bws[1] = 8'h0A; bws[2] = 8'h14; bws[3] = 8'h1E;
    lns[0] = 1; lns[1] = 2; lns[2] = 4;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!link_clk_en && !mainlink_en, "R1", "enables after reset", {link_clk_en, mainlink_en}, 0);
    chk(!busy && !setup_done, "R1", "idle after reset", {busy, setup_done}, 0);
    chk(bw_code == 8'h06 && lane_count == 3'd1, "R1", "bw/lanes after reset",
        {bw_code, 5'(lane_count)}, {8'h06, 5'd1});

    run_case(8'h1E, 4, 8'h14, 0, 1, 0, -1, "R3 pass first");
    run_case(8'h1E, 4, 8'h14, 0, 1, 5, -1, "R4 rate ladder");
    run_case(8'h1E, 4, 8'h14, 0, 2, 4, -1, "R5 R7 lane cuts to floor");
    run_case(8'h14, 4, 8'h12, 0, 2, 3, -1, "R6 other revision");
    run_case(8'h1E, 1, 8'h14, 0, 2, 3, -1, "R7 one-lane start");
    run_case(8'h0A, 2, 8'h14, 0, 3, 4, -1, "R8 retry same");
    run_case(8'h1E, 4, 8'h14, 0, 1, -1, -1, "R10 budget out hard");
    chk(last_attempts == MAX_RETRY + 1, "R10", "attempt count", last_attempts, MAX_RETRY + 1);
    run_case(8'h14, 2, 8'h14, 0, 3, -1, -1, "R13 budget out again");
    chk(last_attempts == MAX_RETRY + 1, "R10", "attempt count again", last_attempts, MAX_RETRY + 1);
    run_case(8'h1E, 4, 8'h14, 0, 1, -1, 2, "R11 abort");
    chk(last_attempts == 3, "R11", "attempts before abort stop", last_attempts, 3);
    run_case(8'h1E, 4, 8'h14, 1, 1, -1, -1, "R12 shallow");
    chk(last_attempts == 1, "R12", "shallow attempts", last_attempts, 1);

    for (int n = 0; n < 25; n++) begin
      run_case(bws[$urandom_range(0, 3)], lns[$urandom_range(0, 2)],
               ($urandom_range(0, 1) != 0) ? 8'h14 : 8'h11,
               $urandom_range(0, 7) == 0, 0, $urandom_range(0, 8),
               ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 4)) : -1,
               "random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule